// File: doc/BRIEF.md
# Programmable Memory Self-Test Sequencer

This block is the control core of an on-chip memory self-test. A sixteen-entry instruction store is filled one bit at a time from a serial test data input. On a start pulse the sequencer walks the stored program. For each instruction it sweeps every address of the attached single-port memory in the order the instruction selects. It drives an address, write data and read/write strobes, and compares every word read against the data it expects.

A mismatch sets a sticky fail flag. Only the first mismatch records its address and the index of the instruction that caught it. A per-instruction loop field sends control back to an earlier entry a set number of times, so that complete march-style algorithms fit in a few entries. The result word is copied into a shift register and clocked out on the serial test data output. Two plain enables stand in for the test-access controller on the load side, and two more on the read-out side.

Top module: `pbist_seq`

## Requirements
- R1: Each instruction is 16 bits, shifted in least significant bit first on `tdi` while `ld_shift` is high, and committed by `ld_update` to the next store entry; the entry pointer returns to 0 on reset and on every accepted start. Field layout: [1:0] operation, [4:2] address order, [5] direction (1 = descending), [8:6] background, [9] invert, [13:10] loop target, [15:14] loop count.
- R2: Operation 0 writes the expected word, operation 1 reads and compares, operation 2 reads and compares then writes the complement of the expected word at the same address, and operation 3 ends the run and sets the done bit.
- R3: Each sweep visits all 2^ADDR_W addresses once. A step counter runs 0 upward and is bit-inverted when the direction bit is 1. The address is the counter itself for order 0 (and 3 to 7), its bit reversal for order 1, and its Gray code (c xor c>>1) for order 2.
- R4: The expected word bit j is 0 for background 0; address bit 0 xor (j odd) for background 1 (checkerboard); address bit 0 for background 2 (row stripe); (j odd) for background 3 (column stripe); 0 for backgrounds 4 to 7. The whole word is inverted when the invert bit is 1.
- R5: When a sweep ends on an instruction with a nonzero loop count N, control returns to the loop target until that instruction has completed N+1 sweeps in total, then moves on. Instructions with count 0 inside the loop body leave the loop state alone. Only one loop is active at a time.
- R6: Every read is compared with the expected word one cycle after the read strobe. The fail bit stays set until the next start. Only the first mismatch of a run records its address and instruction index.
- R7: `st_capture` copies the status word {fail address, fail index[3:0], fail, done} (done in bit 0, fail in bit 1, index in bits 5:2, address from bit 6) into a shift register. Each cycle with `st_shift` high moves it one bit toward `tdo`, least significant bit first.
- R8: While the sequencer runs, `ld_shift`, `ld_update` and `start` have no effect.
- R9: Finishing the sweep of entry 15 without a loop jump ends the run with done set, as operation 3 does.
- R10: The read and write strobes are never high together, and both stay low while not running. After reset the status word is all zeros and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial instruction data |
| ld_shift | input | 1 | Shift `tdi` into the instruction staging register |
| ld_update | input | 1 | Commit the staging register to the next store entry |
| start | input | 1 | Begin a run at entry 0 |
| st_capture | input | 1 | Copy the status word into the output shift register |
| st_shift | input | 1 | Shift the status register one bit toward `tdo` |
| tdo | output | 1 | Serial status output |
| busy | output | 1 | Program running |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_re` |

## Verification
The bench keeps the defaults, ADDR_W = 4 and DATA_W = 8. With a 16-word array, a program that falls through all sixteen entries stays near 256 writes, and a looping run stays a few hundred cycles. With two stuck-at cells injected into the bench memory, linear, bit-reversed and Gray orders reach them in different sequences, so the captured first-fail address shows which order was used. Eight data bits are enough to tell apart every background and its inverse.

// File: rtl/pbist_seq.sv
module pbist_seq #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              ld_shift,
  input  logic              ld_update,
  input  logic              start,
  input  logic              st_capture,
  input  logic              st_shift,
  output logic              tdo,
  output logic              busy,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IW    = 16;
  localparam int DEPTH = 16;
  localparam int ST_W  = 6 + ADDR_W;

  logic [IW-1:0]     prog [DEPTH];
  logic [IW-1:0]     stage;
  logic [3:0]        wptr, pc;
  logic [ADDR_W-1:0] cnt, cnt_d, rev;
  logic              run, phase, loop_act, done, fail;
  logic [1:0]        loop_rem;
  logic [3:0]        fail_idx;
  logic [ADDR_W-1:0] fail_addr;
  logic [ST_W-1:0]   st_sr;
  logic [DATA_W-1:0] bg, expd;

  wire [IW-1:0] ins  = prog[pc];
  wire [1:0]    op   = ins[1:0];
  wire [2:0]    amod = ins[4:2];
  wire          dir  = ins[5];
  wire [2:0]    pat  = ins[8:6];
  wire          inv  = ins[9];
  wire [3:0]    tgt  = ins[13:10];
  wire [1:0]    lc   = ins[15:14];

  wire go       = start && !run;
  wire last     = &cnt;
  wire step     = run && (op != 2'd3) && ((op == 2'd0) || phase);
  wire mismatch = run && phase && (mem_rdata != expd);

  assign cnt_d = dir ? ~cnt : cnt;
  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign rev[i] = cnt_d[ADDR_W-1-i];
  end

  always_comb begin
    case (amod)
      3'd1:    mem_addr = rev;
      3'd2:    mem_addr = cnt_d ^ (cnt_d >> 1);
      default: mem_addr = cnt_d;
    endcase
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_bg
    assign bg[j] = (pat == 3'd1) ? (mem_addr[0] ^ (j % 2 == 1)) :
                   (pat == 3'd2) ? mem_addr[0] :
                   (pat == 3'd3) ? (j % 2 == 1) : 1'b0;
  end
  assign expd = bg ^ {DATA_W{inv}};

  assign busy      = run;
  assign mem_re    = run && !phase && ((op == 2'd1) || (op == 2'd2));
  assign mem_we    = run && ((op == 2'd0) || ((op == 2'd2) && phase));
  assign mem_wdata = phase ? ~expd : expd;
  assign tdo       = st_sr[0];

  always_ff @(posedge clk) begin
    if (ld_update && !run) prog[wptr] <= stage;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      wptr  <= '0;
    end else begin
      if (ld_shift && !run) stage <= {tdi, stage[IW-1:1]};
      if (go) wptr <= '0;
      else if (ld_update && !run) wptr <= wptr + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; phase <= 1'b0; pc <= '0; cnt <= '0;
      loop_act <= 1'b0; loop_rem <= '0;
      done <= 1'b0; fail <= 1'b0; fail_idx <= '0; fail_addr <= '0;
    end else if (go) begin
      run <= 1'b1; phase <= 1'b0; pc <= '0; cnt <= '0;
      loop_act <= 1'b0; loop_rem <= '0;
      done <= 1'b0; fail <= 1'b0; fail_idx <= '0; fail_addr <= '0;
    end else if (run) begin
      if (op == 2'd3) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        if (mem_re) phase <= 1'b1;
        if (mismatch) begin
          fail <= 1'b1;
          if (!fail) begin
            fail_addr <= mem_addr;
            fail_idx  <= pc;
          end
        end
        if (step) begin
          phase <= 1'b0;
          if (!last) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (lc != 2'd0 && !loop_act) begin
              loop_act <= 1'b1;
              loop_rem <= lc - 2'd1;
              pc       <= tgt;
            end else if (lc != 2'd0 && loop_rem != 2'd0) begin
              loop_rem <= loop_rem - 2'd1;
              pc       <= tgt;
            end else begin
              if (lc != 2'd0) loop_act <= 1'b0;
              if (pc == 4'hF) begin
                run  <= 1'b0;
                done <= 1'b1;
              end else pc <= pc + 4'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_sr <= '0;
    else if (st_capture) st_sr <= {fail_addr, fail_idx, fail, done};
    else if (st_shift) st_sr <= st_sr >> 1;
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!mem_re && !mem_we));
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !go) |=> fail);
  p_first_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !go) |=> ($stable(fail_addr) && $stable(fail_idx)));
  p_cmp_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase) |-> (mem_addr == $past(mem_addr)));
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run);
  p_load_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(wptr) && $stable(stage)));
endmodule

// File: tb/pbist_seq_tb.sv
module pbist_seq_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SW = 6 + AW;

  function automatic logic [15:0] ins(int op, int md, int dr, int pt, int iv, int tg, int lc);
    return {lc[1:0], tg[3:0], iv[0], pt[2:0], dr[0], md[2:0], op[1:0]};
  endfunction

  localparam logic [15:0] ENDI = 16'h0003;

  typedef struct packed {
    logic [15:0] i0, i1, i2, i3;
    logic        fe;
    logic [3:0]  fa0, fa1;
    logic [2:0]  fb;
    logic        fv;
    logic        ce;
    logic [3:0]  ca;
    logic [7:0]  cv;
    logic [9:0]  st, nw, nr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{ins(0,0,0,0,0,0,0), ins(1,0,0,0,0,0,0), ENDI, ENDI, 1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00, 10'd1,   10'd16, 10'd16},
    '{ins(0,0,0,0,0,0,0), ins(1,0,1,0,0,0,0), ENDI, ENDI, 1'b1, 4'd2, 4'd12, 3'd0, 1'b1, 1'b0, 4'd0, 8'h00, 10'd775, 10'd16, 10'd16},
    '{ins(0,0,0,0,0,0,0), ins(1,0,0,0,0,1,2), ENDI, ENDI, 1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00, 10'd1,   10'd16, 10'd48},
    '{ins(0,0,0,0,0,0,0), ins(2,0,0,0,0,0,0), ins(1,0,1,0,1,0,0), ENDI, 1'b1, 4'd9, 4'd9, 3'd7, 1'b0, 1'b0, 4'd0, 8'h00, 10'd587, 10'd32, 10'd32},
    '{ins(0,0,0,0,0,0,1), ins(1,1,0,0,0,0,0), ENDI, ENDI, 1'b1, 4'd3, 4'd8, 3'd2, 1'b1, 1'b0, 4'd0, 8'h00, 10'd519, 10'd32, 10'd16},
    '{ins(0,0,0,0,0,0,0), ins(1,2,1,0,0,0,0), ENDI, ENDI, 1'b1, 4'd15, 4'd8, 3'd3, 1'b1, 1'b0, 4'd0, 8'h00, 10'd519, 10'd16, 10'd16},
    '{ins(0,0,0,3,1,0,0), ENDI, ENDI, ENDI,               1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd4, 8'h55, 10'd1,   10'd16, 10'd0},
    '{ins(0,0,0,2,0,0,0), ENDI, ENDI, ENDI,               1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd7, 8'hFF, 10'd1,   10'd16, 10'd0},
    '{ins(0,0,0,1,0,0,0), ins(1,0,0,1,0,0,0), ENDI, ENDI, 1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd6, 8'hAA, 10'd1,   10'd16, 10'd16},
    '{ins(0,0,0,0,0,0,0), ins(1,0,0,0,0,0,1), ENDI, ENDI, 1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00, 10'd1,   10'd32, 10'd32},
    '{ins(0,0,0,0,1,0,0), ins(2,0,0,0,1,0,0), ins(1,0,0,0,0,0,0), ENDI, 1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd3, 8'h00, 10'd1, 10'd32, 10'd32}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tdi = 1'b0, ld_shift = 1'b0, ld_update = 1'b0, start = 1'b0;
  logic st_capture = 1'b0, st_shift = 1'b0;
  logic tdo, busy, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0, nw = 0, nr = 0, cyc = 0;
  logic fe = 1'b0, fv = 1'b0;
  logic [3:0] fa0 = '0, fa1 = '0;
  logic [2:0] fb = '0;
  logic [DW-1:0] mem [16];

  always #2 clk = ~clk;

  pbist_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tdi(tdi), .ld_shift(ld_shift), .ld_update(ld_update),
    .start(start), .st_capture(st_capture), .st_shift(st_shift), .tdo(tdo), .busy(busy),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) mem[k] <= '0;
      mem_rdata <= '0;
    end else begin
      if (mem_we) begin
        logic [DW-1:0] d;
        d = mem_wdata;
        if (fe && (mem_addr == fa0 || mem_addr == fa1)) d[fb] = fv;
        mem[mem_addr] <= d;
      end
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) nw <= nw + 1;
    if (mem_re) nr <= nr + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(logic [15:0] w);
    for (int b = 0; b < 16; b++) begin
      tdi = w[b]; ld_shift = 1'b1;
      @(negedge clk);
    end
    ld_shift = 1'b0; ld_update = 1'b1;
    @(negedge clk);
    ld_update = 1'b0;
  endtask

  task automatic run_prog();
    nw = 0; nr = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
  endtask

  task automatic read_status(output logic [SW-1:0] s);
    st_capture = 1'b1; @(negedge clk); st_capture = 1'b0;
    for (int k = 0; k < SW; k++) begin
      s[k] = tdo; st_shift = 1'b1;
      @(negedge clk);
    end
    st_shift = 1'b0;
  endtask

  initial begin
    logic [SW-1:0] s;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy after reset", busy, 0);
    chk("R10 strobes after reset", {mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_status(s);
    chk("R10 R7 status after reset", s, 0);

    // R1..R7, R9 via the vector table
    for (int v = 0; v < NV; v++) begin
      fe = VECS[v].fe; fa0 = VECS[v].fa0; fa1 = VECS[v].fa1;
      fb = VECS[v].fb; fv = VECS[v].fv;
      load(VECS[v].i0); load(VECS[v].i1); load(VECS[v].i2); load(VECS[v].i3);
      run_prog();
      read_status(s);
      chk($sformatf("R1 R2 R3 R5 R6 R7 status vec %0d", v), s, VECS[v].st);
      chk($sformatf("R2 R5 writes vec %0d", v), nw, VECS[v].nw);
      chk($sformatf("R2 R5 reads vec %0d", v), nr, VECS[v].nr);
      if (VECS[v].ce) chk($sformatf("R4 data vec %0d", v), mem[VECS[v].ca], VECS[v].cv);
    end
    fe = 1'b0;

    // R9: no end instruction, fall off entry 15
    for (int e = 0; e < 16; e++) load(ins(0,0,0,0,0,0,0));
    run_prog();
    read_status(s);
    chk("R9 done after last entry", s, 1);
    chk("R9 writes over sixteen entries", nw, 256);

    // R8: load and start ignored while running
    load(ins(0,0,0,0,0,0,0)); load(ins(1,0,0,0,0,1,2)); load(ENDI);
    nw = 0; nr = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 busy mid run", busy, 1);
    load(ENDI);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
    chk("R8 writes unaffected by mid-run start", nw, 16);
    chk("R8 reads unaffected by mid-run start", nr, 48);
    run_prog();
    chk("R8 program kept: reads", nr, 48);
    chk("R8 program kept: writes", nw, 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule